// File: doc/BRIEF.md
# D-Channel Priority Access Arbiter

This block decides who may send on the shared upstream signalling (D) channel. Two kinds of sender compete for it. Local HDLC controllers sit on a time-multiplexed serial bus. Remote terminals sit on the four-wire subscriber line. On every frame the block takes in the upstream D bits and keeps a running count of consecutive logic ones. It also takes the request flag of the local controller, which is active low. From these it drives two outputs. The first is a Stop/Go indication, which the frame formatter places in the downstream status octet. The second is an echo-bit stream sent back toward the line terminals.

A local controller is gated through Stop/Go. A value of 1 means stop and 0 means go. The line terminals are held off by inverting their echo bits, so each terminal sees a collision and backs off. A grant is given only after the channel has been idle long enough: the ones count must reach a priority threshold of 8 or 10, chosen by one configuration bit. The grant then lasts until the controller withdraws its request. When arbitration is switched off, the echo bits pass through unchanged and Stop/Go reads stop.

Top module: `dch_prio_arb`

## Requirements
- R1: After reset, `stop_go` is 1, `echo_dn` is 0 and the ones count is 0.
- R2: The ones count changes only on a clock where `frame_stb` is 1. On such a clock, each lane of `d_up` is examined in turn. A 1 adds one to the count and a 0 clears it to zero. Values on `d_up` with `frame_stb` at 0 have no effect on the count.
- R3: The count saturates at the selected threshold and never wraps around.
- R4: The threshold is 8 consecutive ones when `prio_hi` is 0 and 10 when `prio_hi` is 1.
- R5: A grant starts on a strobe clock when all four of these hold: the arbiter is idle, `arb_en` is 1, `loc_req_n` is 0, and the count after this frame's bits is at or above the threshold. From the next clock, `stop_go` reads 0.
- R6: A grant never starts while the count after the frame is below the threshold. A pending request waits with `stop_go` at 1.
- R7: A grant lasts while `loc_req_n` stays 0. On the clock after `loc_req_n` rises, the arbiter is idle and `stop_go` is 1.
- R8: On each strobe clock, `echo_dn` is loaded with `d_up`. Each lane is inverted when a grant was active before that clock edge and passed through unchanged otherwise. Between strobes, `echo_dn` holds its value.
- R9: With `arb_en` at 0, `stop_go` reads 1 at once, any grant is cleared, no new grant starts, and echo bits pass through uninverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | High for one clock when `d_up` holds a valid bit pair |
| d_up | input | 2 | Upstream D bits of the frame; lane 0 is taken first |
| loc_req_n | input | 1 | Local controller request: 0 means request, 1 means released |
| prio_hi | input | 1 | Threshold select: 0 gives 8 ones, 1 gives 10 ones |
| arb_en | input | 1 | Arbitration enable |
| stop_go | output | 1 | Stop/Go indication: 1 is stop, 0 is go |
| echo_dn | output | 2 | Echo bits toward the line terminals |

## Verification
The bench goes after several ways the arbiter could grant too early or hold a grant wrongly.

- **Early grant.** A request raised while the count is short must wait. A design that granted on the request alone would drop Stop/Go too soon.
- **Wrong threshold.** With the high threshold selected, a design that compared against the low one would grant after 8 ones instead of 10.
- **Wrapping counter.** After a long run of ones, a counter that wrapped instead of saturating would refuse a valid grant.
- **Strobe ignored.** D bits shown to the block between strobes must not be counted; a design that counted them would grant early.
- **Echo timing.** Echo inversion is checked frame by frame across grant entry and exit. An inversion shifted by one frame, or left on after release, is caught.
- **Disable.** A grant is removed by clearing the enable, and the bench checks that Stop/Go returns to stop at once.

// File: rtl/dch_arb_pkg.sv
package dch_arb_pkg;
   typedef enum logic {
      ARB_IDLE  = 1'b0,
      ARB_GRANT = 1'b1
   } arb_state_e;
endpackage

// File: rtl/dch_ones_cnt.sv
module dch_ones_cnt #(
   parameter int LANES  = 2,
   parameter int THR_LO = 8,
   parameter int THR_HI = 10,
   localparam int CNT_W = $clog2(THR_HI + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic [LANES-1:0] bits_in,
   input  logic             prio_hi,
   output logic [CNT_W-1:0] cnt_next,
   output logic             at_thr
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] thr;

   assign thr = prio_hi ? CNT_W'(THR_HI) : CNT_W'(THR_LO);

   always_comb begin
      cnt_next = cnt_q;
      for (int i = 0; i < LANES; i++) begin
         if (!bits_in[i])          cnt_next = '0;
         else if (cnt_next >= thr) cnt_next = thr;
         else                      cnt_next = cnt_next + 1'b1;
      end
   end

   assign at_thr = (cnt_next >= thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (stb) cnt_q <= cnt_next;
   end

   // R3
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(THR_HI));

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stb) |-> $stable(cnt_q));
endmodule

// File: rtl/dch_grant_fsm.sv
module dch_grant_fsm
   import dch_arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic at_thr,
   input  logic req_n,
   input  logic en,
   output logic grant
);
   arb_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!en) begin
         st_d = ARB_IDLE;
      end else begin
         unique case (st_q)
            ARB_IDLE:  if (stb && !req_n && at_thr) st_d = ARB_GRANT;
            ARB_GRANT: if (req_n)                   st_d = ARB_IDLE;
            default:                                st_d = ARB_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ARB_IDLE;
      else        st_q <= st_d;
   end

   assign grant = (st_q == ARB_GRANT);

   // R6
   grant_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant) |-> $past(at_thr && stb && !req_n && en));

   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && req_n) |=> !grant);
endmodule

// File: rtl/dch_echo_lanes.sv
module dch_echo_lanes #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic [LANES-1:0] bits_in,
   input  logic             invert,
   output logic [LANES-1:0] echo
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   echo[g] <= 1'b0;
         else if (stb) echo[g] <= bits_in[g] ^ invert;
      end
   end

   // R8
   echo_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stb) |-> (echo == ($past(bits_in) ^ {LANES{$past(invert)}})));

   // R8
   echo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stb) |-> $stable(echo));
endmodule

// File: rtl/dch_prio_arb.sv
module dch_prio_arb #(
   parameter int LANES  = 2,
   parameter int THR_LO = 8,
   parameter int THR_HI = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_stb,
   input  logic [LANES-1:0] d_up,
   input  logic             loc_req_n,
   input  logic             prio_hi,
   input  logic             arb_en,
   output logic             stop_go,
   output logic [LANES-1:0] echo_dn
);
   localparam int CNT_W = $clog2(THR_HI + 1);

   if (LANES < 1) begin : g_bad_lanes
      $error("dch_prio_arb: LANES must be at least 1");
   end
   if (THR_LO < 1 || THR_LO >= THR_HI) begin : g_bad_thr
      $error("dch_prio_arb: need 1 <= THR_LO < THR_HI");
   end

   logic [CNT_W-1:0] cnt_next;
   logic             at_thr;
   logic             grant_q;
   logic             grant_eff;

   dch_ones_cnt #(
      .LANES (LANES),
      .THR_LO(THR_LO),
      .THR_HI(THR_HI)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (frame_stb),
      .bits_in (d_up),
      .prio_hi (prio_hi),
      .cnt_next(cnt_next),
      .at_thr  (at_thr)
   );

   dch_grant_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (frame_stb),
      .at_thr(at_thr),
      .req_n (loc_req_n),
      .en    (arb_en),
      .grant (grant_q)
   );

   assign grant_eff = grant_q & arb_en;
   assign stop_go   = ~grant_eff;

   dch_echo_lanes #(
      .LANES(LANES)
   ) u_echo (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (frame_stb),
      .bits_in(d_up),
      .invert (grant_eff),
      .echo   (echo_dn)
   );

   // R9
   disabled_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_en |-> stop_go);

   // R5
   go_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_go) |-> $past(!loc_req_n && frame_stb));
endmodule

// File: tb/dch_prio_arb_bench.sv
module dch_prio_arb_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 16;
   // {d_up[1:0], loc_req_n, exp_stop_go, exp_echo[1:0]} ; threshold 8, enabled
   localparam logic [5:0] VEC [NVEC] = '{
      6'b11_1_1_11, 6'b11_0_1_11, 6'b11_0_1_11, 6'b11_0_0_11,
      6'b01_0_0_10, 6'b00_0_0_11, 6'b11_1_1_00, 6'b11_0_1_11,
      6'b10_0_1_10, 6'b11_0_1_11, 6'b11_0_1_11, 6'b11_0_1_11,
      6'b11_0_0_11, 6'b11_1_1_00, 6'b11_0_0_11, 6'b11_1_1_00
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic [1:0] d_up = 2'b00;
   logic       loc_req_n = 1'b1;
   logic       prio_hi = 1'b0;
   logic       arb_en = 1'b1;
   logic       stop_go;
   logic [1:0] echo_dn;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dch_prio_arb u_dch_prio_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_stb(frame_stb),
      .d_up     (d_up),
      .loc_req_n(loc_req_n),
      .prio_hi  (prio_hi),
      .arb_en   (arb_en),
      .stop_go  (stop_go),
      .echo_dn  (echo_dn)
   );

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {stop_go,echo}=%b expected %b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; frame_stb = 1'b0; d_up = 2'b00; loc_req_n = 1'b1;
      prio_hi = 1'b0; arb_en = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // present one frame, return after the update at the next negedge
   task automatic frame(input logic [1:0] d, input logic rq_n);
      d_up = d; loc_req_n = rq_n; frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      do_reset();
      #1;
      // R1 reset state
      check("R1", {stop_go, echo_dn}, 3'b100);

      // R5 R6 R7 R8 table walk, threshold 8
      @(negedge clk);
      for (int i = 0; i < NVEC; i++) begin
         frame(VEC[i][5:4], VEC[i][3]);
         check($sformatf("R5/R6/R7/R8 vec %0d", i), {stop_go, echo_dn}, VEC[i][2:0]);
      end

      // R4 threshold 10
      do_reset();
      prio_hi = 1'b1;
      for (int i = 0; i < 4; i++) frame(2'b11, 1'b0);
      check("R4 no grant at 8 with high threshold", {stop_go, echo_dn}, 3'b111);
      frame(2'b11, 1'b0);
      check("R4 grant at 10", {stop_go, echo_dn}, 3'b011);

      // R9 disable while granted, then pass-through
      arb_en = 1'b0;
      #1;
      check("R9 stop at once when disabled", {stop_go, echo_dn}, 3'b111);
      @(negedge clk);
      frame(2'b01, 1'b0);
      check("R9 echo passes when disabled", {stop_go, echo_dn}, 3'b101);
      for (int i = 0; i < 5; i++) frame(2'b11, 1'b0);
      check("R9 no grant while disabled", {stop_go, echo_dn}, 3'b111);

      // R3 long run of ones must not wrap
      do_reset();
      prio_hi = 1'b1;
      for (int i = 0; i < 10; i++) frame(2'b11, 1'b1);
      frame(2'b11, 1'b0);
      check("R3 saturated count still grants", {stop_go, echo_dn}, 3'b011);

      // R2 bits without strobe are ignored
      do_reset();
      d_up = 2'b11; loc_req_n = 1'b0;
      repeat (12) @(negedge clk);
      for (int i = 0; i < 3; i++) frame(2'b11, 1'b0);
      check("R2 unstrobed ones not counted", {stop_go, echo_dn}, 3'b111);
      frame(2'b11, 1'b0);
      check("R2 grant after four strobed frames", {stop_go, echo_dn}, 3'b011);
      d_up = 2'b00;
      repeat (3) @(negedge clk);
      check("R8 echo holds between strobes", {stop_go, echo_dn}, 3'b011);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule